// File: doc/BRIEF.md
# Slow Clock Failure Monitor with Failover

This block watches an external low-frequency clock, nominally 32 kHz, from a faster reference clock domain. It looks for transitions of the slow clock. When no transition arrives within a programmable number of reference cycles, it latches an interrupt. If backup switching is enabled, it also forces the slow-clock source select over to the internal oscillator. No software takes part in this. The reference domain keeps running in deep sleep, so the failover still happens there and wake-up timers keep their clock.

Each failure disarms detection. The interrupt then stays latched until software clears it. No further detection or switching takes place until a restore command. A restore returns the select to the external source and re-arms the monitor. If the external clock is still dead at that point, the monitor fails over again after one timeout.

Monitoring applies only while detection is enabled and the external source is the configured slow clock. The analog oscillators and the glitch-free mux are not part of this block. The block only produces the select bit.

Top module: `slow_clk_monitor`

## Requirements
- R1: While rst_ni is low and right after reset, irq_o is 0, and src_int_o equals the inverse of ext_sel_i.
- R2: With the monitor armed, detection enabled, ext_sel_i high and xclk_i not toggling, irq_o rises exactly timeout_i + 1 reference cycles after the clock edge that samples restore_i high.
- R3: When xclk_i transitions seen in the reference domain are exactly P cycles apart, no failure occurs if timeout_i >= P - 1, and a failure occurs if timeout_i <= P - 2.
- R4: On a failure, src_int_o goes to 1 in the same cycle that irq_o rises if backup_en_i is 1. If backup_en_i is 0, src_int_o stays 0.
- R5: irq_o stays 1 until irq_clr_i is sampled high, and it is 0 from the following cycle.
- R6: After a failure, detection is disarmed. With irq_o cleared and xclk_i still stopped, irq_o stays 0 and src_int_o keeps its value until a restore.
- R7: A restore sets src_int_o to 0 from the next cycle and re-arms detection, so a still-stopped clock fails again after timeout_i + 1 cycles.
- R8: While det_en_i is 0 or ext_sel_i is 0, no failure is detected, however long xclk_i stays stopped.
- R9: src_int_o is 1 whenever ext_sel_i is 0. Value 1 selects the internal oscillator and 0 selects the external clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, kept running in sleep |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xclk_i | input | 1 | External slow clock (asynchronous) |
| ext_sel_i | input | 1 | Configuration selects the external source |
| det_en_i | input | 1 | Stop detection enable |
| backup_en_i | input | 1 | Automatic failover enable |
| timeout_i | input | TW | Stop timeout in reference cycles |
| restore_i | input | 1 | Return to external source and re-arm |
| irq_clr_i | input | 1 | Clear latched interrupt |
| irq_o | output | 1 | Latched failure interrupt |
| src_int_o | output | 1 | Slow-clock select: 1 internal, 0 external |

## Verification
The hardest situation to reach is the exact boundary between a slow clock that is merely slow and one that counts as stopped. The bench drives xclk_i from a divider that is locked to the reference clock, so transitions reach the monitor at a known, fixed spacing P. For each spacing, it sweeps the timeout to the values just above and just below P - 1. The re-arm path is reached by issuing restore_i while the clock is still held still. The bench then measures the cycle at which the failure repeats.

// File: rtl/slowmon_pkg.sv
package slowmon_pkg;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} src_e;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/slowmon_edge_sync.sv
module slowmon_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xclk_i,
  output logic edge_o
);
  import slowmon_pkg::*;
  logic [SYNC_STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SYNC_STAGES-1:0], xclk_i};
  end

  assign edge_o = sr_q[SYNC_STAGES] ^ sr_q[SYNC_STAGES-1];
endmodule

// File: rtl/slowmon_stop_timer.sv
module slowmon_stop_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          edge_i,
  input  logic          restart_i,
  input  logic [TW-1:0] timeout_i,
  output logic          hit_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!active_i || edge_i || restart_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)               cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = active_i && !edge_i && (cnt_q >= timeout_i);

  assert_cnt_clear_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> cnt_q == '0);
  assert_cnt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/slowmon_failover_ctrl.sv
module slowmon_failover_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic backup_en_i,
  input  logic restore_i,
  input  logic irq_clr_i,
  output logic armed_o,
  output logic irq_o,
  output slowmon_pkg::src_e src_o
);
  import slowmon_pkg::*;
  logic armed_q, irq_q;
  src_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
      src_q   <= SRC_EXT;
    end else begin
      if (hit_i) begin
        armed_q <= 1'b0;
        irq_q   <= 1'b1;
        if (backup_en_i) src_q <= SRC_INT;
      end else begin
        if (irq_clr_i) irq_q <= 1'b0;
        if (restore_i) begin
          armed_q <= 1'b1;
          src_q   <= SRC_EXT;
        end
      end
    end
  end

  assign armed_o = armed_q;
  assign irq_o   = irq_q;
  assign src_o   = src_q;

  assert_no_hit_disarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !hit_i);
  assert_switch_disarms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_q) |-> !armed_q && irq_q);
  assert_irq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !irq_clr_i |=> irq_q);
  assert_restore_rearms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !hit_i |=> armed_q && src_q == SRC_EXT);
endmodule

// File: rtl/slow_clk_monitor.sv
module slow_clk_monitor #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xclk_i,
  input  logic          ext_sel_i,
  input  logic          det_en_i,
  input  logic          backup_en_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          restore_i,
  input  logic          irq_clr_i,
  output logic          irq_o,
  output logic          src_int_o
);
  import slowmon_pkg::*;
  logic edge_w, hit_w, armed_w, active_w;
  src_e src_w;

  slowmon_edge_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .xclk_i(xclk_i), .edge_o(edge_w)
  );

  assign active_w = armed_w && det_en_i && ext_sel_i;

  slowmon_stop_timer #(.TW(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_w), .edge_i(edge_w),
    .restart_i(restore_i), .timeout_i(timeout_i), .hit_o(hit_w)
  );

  slowmon_failover_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_w), .backup_en_i(backup_en_i),
    .restore_i(restore_i), .irq_clr_i(irq_clr_i), .armed_o(armed_w),
    .irq_o(irq_o), .src_o(src_w)
  );

  assign src_int_o = !ext_sel_i || (src_w == SRC_INT);

  assert_gated_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en_i || !ext_sel_i) && !irq_o |=> !irq_o);
  assert_int_when_unselected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sel_i |-> src_int_o);
endmodule

// File: tb/slow_clk_monitor_test.sv
`timescale 1ns/1ps
module slow_clk_monitor_test;
  localparam int TW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xclk = 1'b0, ext_sel = 1'b1, det_en = 1'b1, backup_en = 1'b1;
  logic [TW-1:0] tmo = 8'd4;
  logic restore = 1'b0, irq_clr = 1'b0;
  logic irq, src_int;
  int n_chk = 0, n_bad = 0;
  int tog_p = 4, tog_c = 0;
  logic tog_en = 1'b0;

  always #2 clk = ~clk;

  slow_clk_monitor #(.TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .xclk_i(xclk), .ext_sel_i(ext_sel),
    .det_en_i(det_en), .backup_en_i(backup_en), .timeout_i(tmo),
    .restore_i(restore), .irq_clr_i(irq_clr), .irq_o(irq), .src_int_o(src_int)
  );

  always @(negedge clk) begin
    if (tog_en) begin
      if (tog_c >= tog_p - 1) begin xclk = ~xclk; tog_c = 0; end
      else tog_c = tog_c + 1;
    end else tog_c = 0;
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rearm();
    irq_clr = 1'b1; restore = 1'b1;
    tick();
    irq_clr = 1'b0; restore = 1'b0;
  endtask

  function automatic int wait_irq(input int lim);
    return lim;
  endfunction

  task automatic measure(output int n);
    n = 0;
    for (int i = 1; i <= 300; i++) begin
      tick();
      if (irq) begin n = i; break; end
    end
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    chk("R1 irq in reset", irq, 0);
    chk("R1 src in reset", src_int, 0);
    ext_sel = 1'b0; #1;
    chk("R9 src when external unselected", src_int, 1);
    ext_sel = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);

    // R2/R4/R7 latency sweep with stopped clock, both backup settings
    for (int b = 0; b < 2; b++) begin
      for (int t = 0; t <= 12; t++) begin
        backup_en = b[0]; tmo = TW'(t);
        rearm();
        chk("R7 src back to external after restore", src_int, 0);
        measure(n);
        chk("R2 failure latency", n, t + 1);
        chk("R4 src follows backup enable", src_int, b);
      end
    end

    // R5 latch and clear, R6 disarmed
    backup_en = 1'b1; tmo = 8'd3;
    rearm(); measure(n);
    for (int i = 0; i < 20; i++) tick();
    chk("R5 irq held", irq, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R5 irq cleared next cycle", irq, 0);
    for (int i = 0; i < 40; i++) tick();
    chk("R6 no refire while disarmed", irq, 0);
    chk("R6 src held while disarmed", src_int, 1);

    // R8 gating
    det_en = 1'b0; rearm();
    for (int i = 0; i < 50; i++) tick();
    chk("R8 no irq with detection off", irq, 0);
    det_en = 1'b1; ext_sel = 1'b0; rearm();
    for (int i = 0; i < 50; i++) tick();
    chk("R8 no irq with external unselected", irq, 0);
    chk("R9 src internal when unselected", src_int, 1);
    ext_sel = 1'b1;
    measure(n);
    chk("R8 detection resumes", n, 4);

    // R3 boundary sweep on edge spacing
    for (int p = 3; p <= 8; p++) begin
      for (int d = 0; d < 2; d++) begin
        tog_p = p; tog_en = 1'b1;
        tmo = TW'(p - 1 - d);
        for (int i = 0; i < 4 * p; i++) tick();
        rearm();
        n = 0;
        for (int i = 0; i < 12 * p; i++) begin tick(); if (irq) n = 1; end
        chk($sformatf("R3 spacing %0d timeout %0d", p, p - 1 - d), n, d);
      end
    end
    tog_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule